// File: doc/BRIEF.md
# Microcoded Control-Sequence Sequencer

This block is a controller whose whole behaviour lives in a microprogram table. Each table word describes one control step. That step occupies the controller for exactly one clock cycle. During that cycle the word drives a vector of control outputs and a small vector of event strobes. Any control bit the word does not claim falls back to a fixed default value. After the step, control passes to the next word in table order. A word can instead jump unconditionally to a target, choose between two targets using a masked comparison of predicate inputs, or return the controller to idle.

The controller waits in an idle state with every output at its default until a start request is seen. It then runs from the entry word. The predicates are examined combinationally during the cycle in which the branch word is active, and that cycle costs nothing extra. A program that needs the predicates to reflect a datapath result of the previous step must therefore place an empty wait step in front of the branch. The built-in program contains such a wait step and exercises every kind of step.

Top module: `ucseq_ctrl`

## Requirements
- R1: After synchronous reset, and for as long as no start is seen, `ctl_out` equals the default 8'h0A and `evt` is 0.
- R2: If `start` is high at a rising edge while idle, the output after that edge shows word 0 (the entry word).
- R3: While a word is active, each `ctl_out` bit whose assign-mask bit is 1 shows the word's value bit, and each other bit shows its default bit from 8'h0A.
- R4: A word with step code 2'b00 passes control to the word at the next address.
- R5: A word with step code 2'b01 passes control to its primary target, and the words in between are never shown.
- R6: A word with step code 2'b10 goes to its primary target when every predicate bit selected by its mask equals the matching polarity bit, and otherwise goes to its alternate target. The predicates are sampled at the edge that ends the branch word.
- R7: `evt` is 1 only in the cycles of words whose event field is set, so each event is a pulse exactly one cycle long.
- R8: A word with step code 2'b11 returns the controller to idle at the next edge.
- R9: `start` has no effect while the controller is running.
- R10: Synchronous reset returns the controller to idle from any word.
- R11: The built-in program is as follows. Unlisted words: step code 11 with an empty mask.

  | Word | Step | Assign mask / value | Event | Targets and predicates |
  |---|---|---|---|---|
  | 0 | 00 | 0F / 05 | none | — |
  | 1 | 00 | 30 / 30 | none | — |
  | 2 | 00 | empty | none | wait step |
  | 3 | 10 | 80 / 80 | none | mask 111, polarity 110; primary 4, alternate 0 |
  | 4 | 00 | FF / A5 | none | — |
  | 5 | 00 | empty | bit 0 | — |
  | 6 | 01 | 02 / 00 | bit 1 | target 8 |
  | 7 | 00 | FF / 77 | none | — |
  | 8 | 10 | 40 / 40 | none | mask 001, polarity 001; primary 10, alternate 9 |
  | 9 | 11 | 03 / 01 | none | — |
  | 10 | 11 | 0C / 00 | none | — |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| pred | input | 3 | Predicate inputs for conditional steps |
| ctl_out | output | 8 | Control outputs of the active word, or defaults |
| evt | output | 2 | One-cycle event strobes |

## Verification
Each result is due one rising edge after the edge that changed the step. A start request seen at edge N shows word 0 after edge N. A branch resolved at edge N shows its target after edge N. A return-to-idle word gives default outputs after the edge that ends it. The bench keeps a behavioural model that steps at every rising edge using the same sampled inputs. The bench compares both outputs against that model at the following falling edge, so every check lands inside the cycle where the result must hold. The bench changes predicates only at falling edges. It times those changes so that the branch at word 3 and the branch at word 8 each take both of their directions.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  localparam int OUT_W   = 8;
  localparam int EV_W    = 2;
  localparam int PRED_W  = 3;
  localparam int ADDR_W  = 5;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ENTRY    = '0;
  localparam logic [OUT_W-1:0]  OUT_DFLT = 8'h0A;

  typedef enum logic [1:0] {
    STEP_NEXT = 2'b00,
    STEP_JUMP = 2'b01,
    STEP_COND = 2'b10,
    STEP_STOP = 2'b11
  } step_e;

  typedef struct packed {
    logic [OUT_W-1:0]  amask;
    logic [OUT_W-1:0]  val;
    logic [EV_W-1:0]   ev;
    step_e             step;
    logic [ADDR_W-1:0] tgt;
    logic [ADDR_W-1:0] alt;
    logic [PRED_W-1:0] pmask;
    logic [PRED_W-1:0] ppol;
  } uword_t;

  localparam int WORD_W = $bits(uword_t);

  function automatic uword_t mk_word(
    step_e             st,
    logic [OUT_W-1:0]  am,
    logic [OUT_W-1:0]  vl,
    logic [EV_W-1:0]   ev,
    logic [ADDR_W-1:0] tg,
    logic [ADDR_W-1:0] al,
    logic [PRED_W-1:0] pm,
    logic [PRED_W-1:0] pp
  );
    uword_t w;
    w.amask = am;
    w.val   = vl;
    w.ev    = ev;
    w.step  = st;
    w.tgt   = tg;
    w.alt   = al;
    w.pmask = pm;
    w.ppol  = pp;
    return w;
  endfunction

  // Built-in control program; every unlisted word stops with defaults.
  function automatic uword_t prog_word(int unsigned a);
    case (a)
      0:  return mk_word(STEP_NEXT, 8'h0F, 8'h05, 2'b00, 5'd0,  5'd0, 3'b000, 3'b000);
      1:  return mk_word(STEP_NEXT, 8'h30, 8'h30, 2'b00, 5'd0,  5'd0, 3'b000, 3'b000);
      2:  return mk_word(STEP_NEXT, 8'h00, 8'h00, 2'b00, 5'd0,  5'd0, 3'b000, 3'b000);
      3:  return mk_word(STEP_COND, 8'h80, 8'h80, 2'b00, 5'd4,  5'd0, 3'b111, 3'b110);
      4:  return mk_word(STEP_NEXT, 8'hFF, 8'hA5, 2'b00, 5'd0,  5'd0, 3'b000, 3'b000);
      5:  return mk_word(STEP_NEXT, 8'h00, 8'h00, 2'b01, 5'd0,  5'd0, 3'b000, 3'b000);
      6:  return mk_word(STEP_JUMP, 8'h02, 8'h00, 2'b10, 5'd8,  5'd0, 3'b000, 3'b000);
      7:  return mk_word(STEP_NEXT, 8'hFF, 8'h77, 2'b00, 5'd0,  5'd0, 3'b000, 3'b000);
      8:  return mk_word(STEP_COND, 8'h40, 8'h40, 2'b00, 5'd10, 5'd9, 3'b001, 3'b001);
      9:  return mk_word(STEP_STOP, 8'h03, 8'h01, 2'b00, 5'd0,  5'd0, 3'b000, 3'b000);
      10: return mk_word(STEP_STOP, 8'h0C, 8'h00, 2'b00, 5'd0,  5'd0, 3'b000, 3'b000);
      default: return mk_word(STEP_STOP, 8'h00, 8'h00, 2'b00, 5'd0, 5'd0, 3'b000, 3'b000);
    endcase
  endfunction

endpackage

// File: rtl/ucseq_rom.sv
module ucseq_rom
  import ucseq_pkg::*;
(
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output uword_t            rd_word
);

  uword_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = prog_word(i);
    end
  end

  // Synchronous read with no reset so that a block RAM can hold the table.
  always_ff @(posedge clk) begin
    rd_word <= mem[rd_addr];
  end

endmodule

// File: rtl/ucseq_next.sv
module ucseq_next
  import ucseq_pkg::*;
(
  input  logic              act,
  input  logic [ADDR_W-1:0] pc,
  input  uword_t            word,
  input  logic              start,
  input  logic [PRED_W-1:0] pred,
  output logic              act_nxt,
  output logic [ADDR_W-1:0] pc_nxt
);

  logic [PRED_W-1:0] bit_ok;
  logic              hit;

  genvar g;
  generate
    for (g = 0; g < PRED_W; g++) begin : g_pbit
      assign bit_ok[g] = !word.pmask[g] || (pred[g] == word.ppol[g]);
    end
  endgenerate

  assign hit = &bit_ok;

  always_comb begin
    act_nxt = act;
    pc_nxt  = pc;
    if (!act) begin
      if (start) begin
        act_nxt = 1'b1;
        pc_nxt  = ENTRY;
      end
    end else begin
      case (word.step)
        STEP_NEXT: pc_nxt = pc + 1'b1;
        STEP_JUMP: pc_nxt = word.tgt;
        STEP_COND: pc_nxt = hit ? word.tgt : word.alt;
        default:   act_nxt = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ucseq_outmix.sv
module ucseq_outmix
  import ucseq_pkg::*;
(
  input  logic             act,
  input  uword_t           word,
  output logic [OUT_W-1:0] ctl_out,
  output logic [EV_W-1:0]  evt
);

  genvar g;
  generate
    for (g = 0; g < OUT_W; g++) begin : g_obit
      assign ctl_out[g] = (act && word.amask[g]) ? word.val[g] : OUT_DFLT[g];
    end
    for (g = 0; g < EV_W; g++) begin : g_ebit
      assign evt[g] = act && word.ev[g];
    end
  endgenerate

endmodule

// File: rtl/ucseq_ctrl.sv
module ucseq_ctrl
  import ucseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PRED_W-1:0] pred,
  output logic [OUT_W-1:0]  ctl_out,
  output logic [EV_W-1:0]   evt
);

  logic              act_q;
  logic [ADDR_W-1:0] pc_q;
  logic              act_nxt;
  logic [ADDR_W-1:0] pc_nxt;
  uword_t            word_q;

  ucseq_rom u_rom (
    .clk     (clk),
    .rd_addr (pc_nxt),
    .rd_word (word_q)
  );

  ucseq_next u_next (
    .act     (act_q),
    .pc      (pc_q),
    .word    (word_q),
    .start   (start),
    .pred    (pred),
    .act_nxt (act_nxt),
    .pc_nxt  (pc_nxt)
  );

  ucseq_outmix u_mix (
    .act     (act_q),
    .word    (word_q),
    .ctl_out (ctl_out),
    .evt     (evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      pc_q  <= ENTRY;
    end else begin
      act_q <= act_nxt;
      pc_q  <= pc_nxt;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !start) |=> (!act_q && ctl_out == OUT_DFLT && evt == '0)); // R1

  AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!act_q && start) |=> (act_q && pc_q == ENTRY)); // R2

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (act_q && word_q.step == STEP_NEXT) |=> (act_q && pc_q == ADDR_W'($past(pc_q) + 1'b1))); // R4

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (act_q && word_q.step == STEP_JUMP) |=> (act_q && pc_q == $past(word_q.tgt))); // R5

  AST_COND_PICK: assert property (@(posedge clk) disable iff (rst)
    (act_q && word_q.step == STEP_COND) |=>
      (act_q && (pc_q == $past(word_q.tgt) || pc_q == $past(word_q.alt)))); // R6

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (act_q && word_q.step == STEP_STOP) |=> (!act_q && ctl_out == OUT_DFLT)); // R8

  AST_RUN_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (act_q && start && word_q.step == STEP_NEXT && pc_q != ADDR_W'(DEPTH - 1))
      |=> (pc_q != ENTRY)); // R9

endmodule

// File: tb/sim_ucseq_ctrl.sv
`timescale 1ns/1ps
module sim_ucseq_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [2:0] pred;
  logic [7:0] ctl_out;
  logic [1:0] evt;

  always #2 clk = ~clk;

  ucseq_ctrl u0 (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .pred    (pred),
    .ctl_out (ctl_out),
    .evt     (evt)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    m_act = 0;
  int    m_pc  = 0;
  int    cyc   = 0;
  int    ev_pulses = 0;
  bit    armed = 0;
  bit    seen_a5 = 0;
  bit    seen_77 = 0;
  bit    seen_09 = 0;
  bit    seen_02 = 0;
  bit    seen_r9 = 0;
  bit    seen_r10 = 0;
  string kind = "R1";

  // Model of the built-in program (R11): step, mask, value, event, targets, predicate fields.
  task automatic lookup(input int a, output int st, output int am, output int vl,
                        output int ev, output int tg, output int al, output int pm, output int pp);
    st = 3; am = 0; vl = 0; ev = 0; tg = 0; al = 0; pm = 0; pp = 0;
    case (a)
      0:  begin st = 0; am = 'h0F; vl = 'h05; end
      1:  begin st = 0; am = 'h30; vl = 'h30; end
      2:  begin st = 0; end
      3:  begin st = 2; am = 'h80; vl = 'h80; tg = 4; al = 0; pm = 7; pp = 6; end
      4:  begin st = 0; am = 'hFF; vl = 'hA5; end
      5:  begin st = 0; ev = 1; end
      6:  begin st = 1; am = 'h02; vl = 'h00; ev = 2; tg = 8; end
      7:  begin st = 0; am = 'hFF; vl = 'h77; end
      8:  begin st = 2; am = 'h40; vl = 'h40; tg = 10; al = 9; pm = 1; pp = 1; end
      9:  begin st = 3; am = 'h03; vl = 'h01; end
      10: begin st = 3; am = 'h0C; vl = 'h00; end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference stepping at every rising edge.
  always @(posedge clk) begin
    int st, am, vl, ev, tg, al, pm, pp;
    cyc++;
    armed = 1;
    if (rst) begin
      if (m_act != 0) seen_r10 = 1;
      m_act = 0; m_pc = 0; kind = "R10";
    end else if (m_act == 0) begin
      if (start) begin m_act = 1; m_pc = 0; kind = "R2"; end
      else kind = "R1";
    end else begin
      lookup(m_pc, st, am, vl, ev, tg, al, pm, pp);
      case (st)
        0: begin m_pc = (m_pc + 1) % 32; kind = start ? "R9" : "R4"; end
        1: begin m_pc = tg; kind = "R5"; end
        2: begin
             m_pc = ((((int'(pred)) ^ pp) & pm) == 0) ? tg : al;
             kind = "R6";
           end
        default: begin m_act = 0; kind = "R8"; end
      endcase
      if (start && m_act != 0) seen_r9 = 1;
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    int st, am, vl, ev, tg, al, pm, pp;
    int exp_out, exp_ev;
    if (armed) begin
      exp_out = 'h0A; exp_ev = 0;
      if (m_act != 0) begin
        lookup(m_pc, st, am, vl, ev, tg, al, pm, pp);
        exp_out = (vl & am) | ('h0A & ~am & 'hFF);
        exp_ev  = ev;
      end
      check({kind, " R3 ctl_out"}, int'(ctl_out), exp_out);
      check({kind, " R7 evt"}, int'(evt), exp_ev);
      if (evt != 0) ev_pulses++;
      if (ctl_out == 8'hA5) seen_a5 = 1;
      if (ctl_out == 8'h77) seen_77 = 1;
      if (ctl_out == 8'h09) seen_09 = 1;
      if (ctl_out == 8'h02) seen_02 = 1;
    end
  end

  // Watchdog: an overrun counts as a failure and still reaches the summary.
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired after %0d cycles expected end earlier", cyc);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; pred = 3'b000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);                 // R1 idle defaults checked each cycle

    // Run 1: branch at word 3 taken, branch at word 8 takes its alternate.
    pred = 3'b110; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (14) @(negedge clk);
    check("R6 primary path word 4 seen", int'(seen_a5), 1);
    check("R5 skipped word 7 never shown", int'(seen_77), 0);
    check("R8 alternate word 9 stop seen", int'(seen_09), 1);
    check("R7 event pulse count run 1", ev_pulses, 2);

    // Run 2: branch at word 3 loops back, start held while running (R9), then reset (R10).
    pred = 3'b001; start = 1'b1;
    @(negedge clk);
    repeat (9) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 start while running seen", int'(seen_r9), 1);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 reset from running", int'(seen_r10), 1);
    repeat (3) @(negedge clk);

    // Run 3: word 3 matches, then word 8 matches with p0 high.
    pred = 3'b110; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (7) @(negedge clk);
    pred = 3'b001;
    repeat (6) @(negedge clk);
    check("R6 primary word 10 stop seen", int'(seen_02), 1);
    check("R1 idle after run 3", int'(ctl_out), 'h0A);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule